// File: doc/BRIEF.md
# Peripheral Bus Timeout Watchdog

This block watches a simple request/ready bus between one bus master and a group of low-power peripheral slaves. Each access begins when the master raises its request and ends when the completion signal it sees goes high. The watchdog counts the cycles of every outstanding access. If the selected slave stays silent past a programmable limit, the watchdog ends the transfer itself. It does this by driving completion high for one cycle together with an error flag, so a hung slave cannot stall the master.

On such a forced completion, the block records the address of the stalled access and the identifier of the master that issued it. It also raises a sticky interrupt. The capture registers keep the first fault until software clears the interrupt. A small register port carries the limit, the protection enable, the write-one clear and the read-only capture values. The block runs in one clock domain; the counter runs on the clock supplied as `clk`.

Top module: `bus_timeout_wdog`

## Requirements
- R1: After reset the limit reads 65535, protection is enabled, the interrupt is low, and both capture registers read zero.
- R2: When the slave raises ready in access cycle L (the first request cycle counts as 0) with L not above the limit, `bus_ready` follows the slave in that same cycle and `bus_err` stays low.
- R3: With protection enabled and the slave silent, `bus_ready` and `bus_err` are both high for exactly one cycle, in access cycle limit+1.
- R4: The cycle count restarts at zero for every new access, including one that follows another access with no idle cycle between them.
- R5: A forced completion latches the full access address, which is readable at register index 1.
- R6: A forced completion latches the master identifier, which is readable in bits [6:0] of register index 2.
- R7: A forced completion sets the interrupt (`tmo_irq`, bit 0 of register index 3). The interrupt stays set until a write to register index 0 with bit 17 high clears it; no later write of 0 is needed.
- R8: While the interrupt is pending, a further timeout leaves both capture registers unchanged.
- R9: With protection disabled (bit 16 of register index 0 low), the slave's ready passes through unchanged at any latency, no error is flagged and the interrupt is not set.
- R10: Register index 0 holds the limit in bits [15:0] and the enable in bit 16; bit 17 always reads 0. Read data is registered and appears one clock after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus, counter and registers |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Master request, held until completion |
| bus_addr | input | 32 | Address of the current access |
| bus_uid | input | 7 | Identifier of the issuing master |
| slv_ready | input | 1 | Ready from the addressed slave |
| bus_ready | output | 1 | Completion seen by the master |
| bus_err | output | 1 | Error response, high on forced completion |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| tmo_irq | output | 1 | Sticky timeout interrupt |

## Verification
The assertions check several rules on every cycle. A forced completion lasts a single cycle. It only follows a cycle in which the master requested and the slave was silent. The error flag never appears without completion. A pending interrupt keeps both the capture values and itself stable unless a clear arrives. A disabled watchdog never enters the forcing state. Only the bench scenarios can show the exact cycle of forced completion across the limit sweep, the restart of the count between back-to-back accesses, and that a pass-through completion is not flagged. They also show which fault the capture holds, and the clear-and-recapture sequence as seen through the register port.

// File: rtl/bto_pkg.sv
package bto_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_FORCE = 2'd2
  } bto_state_e;

  localparam int unsigned REG_W = 32;
  localparam int unsigned SEL_W = 2;

  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR = 2'd1;
  localparam logic [SEL_W-1:0] SEL_UID  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd3;

  localparam int unsigned CTRL_EN_BIT  = 16;
  localparam int unsigned CTRL_CLR_BIT = 17;
endpackage

// File: rtl/bto_counter.sv
module bto_counter
  import bto_pkg::*;
#(
  parameter int unsigned THR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             req_i,
  input  logic             ready_i,
  output logic             hit_o,
  output logic             force_o
);
  bto_state_e       state_q;
  logic [THR_W-1:0] cnt_q;
  logic [THR_W-1:0] cur;
  logic             stall;

  always_comb begin
    cur   = (state_q == ST_COUNT) ? cnt_q : '0;
    stall = en_i & req_i & ~ready_i & (state_q != ST_FORCE);
    hit_o = stall & (cur >= thr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (state_q == ST_FORCE) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (hit_o) begin
      state_q <= ST_FORCE;
      cnt_q   <= '0;
    end else if (stall) begin
      state_q <= ST_COUNT;
      cnt_q   <= cur + 1'b1;
    end else begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end
  end

  assign force_o = (state_q == ST_FORCE);

  p_force_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    force_o |=> !force_o);

  p_force_after_stall_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(force_o) |-> $past(req_i & ~ready_i & en_i));

  p_no_force_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (state_q != ST_FORCE));
endmodule

// File: rtl/bto_capture.sv
module bto_capture #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned UID_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [UID_W-1:0]  uid_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [UID_W-1:0]  uid_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [UID_W-1:0]  uid_q;
  logic              irq_q;
  logic              take;

  assign take = hit_i & (~irq_q | clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      uid_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (take) begin
        addr_q <= addr_i;
        uid_q  <= uid_i;
      end
      irq_q <= hit_i | (irq_q & ~clr_i);
    end
  end

  assign addr_o = addr_q;
  assign uid_o  = uid_q;
  assign irq_o  = irq_q;

  p_hold_pending_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_q & ~clr_i) |=> ($stable(addr_q) && $stable(uid_q)));

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_q & ~clr_i) |=> irq_q);

  p_irq_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_i & ~hit_i) |=> !irq_q);
endmodule

// File: rtl/bto_regs.sv
module bto_regs
  import bto_pkg::*;
#(
  parameter int unsigned      THR_W     = 16,
  parameter int unsigned      ADDR_W    = 32,
  parameter int unsigned      UID_W     = 7,
  parameter logic [THR_W-1:0] THR_RESET = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [UID_W-1:0]  cap_uid_i,
  input  logic              irq_i,
  output logic [THR_W-1:0]  thr_o,
  output logic              en_o,
  output logic              clr_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [THR_W-1:0] thr_q;
  logic             en_q;
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] rdata_q;
  logic             ctrl_wr;
  logic             unused_wbits;

  assign ctrl_wr      = we_i & (sel_i == SEL_CTRL);
  assign clr_o        = ctrl_wr & wdata_i[CTRL_CLR_BIT];
  assign unused_wbits = ^wdata_i[REG_W-1:CTRL_CLR_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= THR_RESET;
      en_q  <= 1'b1;
    end else if (ctrl_wr) begin
      thr_q <= wdata_i[THR_W-1:0];
      en_q  <= wdata_i[CTRL_EN_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel_i)
      SEL_CTRL: begin
        rd_mux[THR_W-1:0]  = thr_q;
        rd_mux[CTRL_EN_BIT] = en_q;
      end
      SEL_ADDR: rd_mux = REG_W'(cap_addr_i);
      SEL_UID:  rd_mux = REG_W'(cap_uid_i);
      default:  rd_mux[0] = irq_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign thr_o   = thr_q;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;

  p_ctrl_write_r10: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (thr_q == $past(wdata_i[THR_W-1:0])) && (en_q == $past(wdata_i[CTRL_EN_BIT])));
endmodule

// File: rtl/bus_timeout_wdog.sv
module bus_timeout_wdog
  import bto_pkg::*;
#(
  parameter int unsigned      THR_W     = 16,
  parameter int unsigned      ADDR_W    = 32,
  parameter int unsigned      UID_W     = 7,
  parameter logic [THR_W-1:0] THR_RESET = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [UID_W-1:0]  bus_uid,
  input  logic              slv_ready,
  output logic              bus_ready,
  output logic              bus_err,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              tmo_irq
);
  logic [THR_W-1:0]  thr;
  logic              en;
  logic              clr;
  logic              hit;
  logic              forcing;
  logic [ADDR_W-1:0] cap_addr;
  logic [UID_W-1:0]  cap_uid;
  logic              irq;

  bto_regs #(
    .THR_W(THR_W), .ADDR_W(ADDR_W), .UID_W(UID_W), .THR_RESET(THR_RESET)
  ) i_regs (
    .clk(clk), .rst(rst), .we_i(cfg_we), .sel_i(cfg_sel), .wdata_i(cfg_wdata),
    .cap_addr_i(cap_addr), .cap_uid_i(cap_uid), .irq_i(irq),
    .thr_o(thr), .en_o(en), .clr_o(clr), .rdata_o(cfg_rdata)
  );

  bto_counter #(.THR_W(THR_W)) i_counter (
    .clk(clk), .rst(rst), .en_i(en), .thr_i(thr), .req_i(bus_req),
    .ready_i(slv_ready), .hit_o(hit), .force_o(forcing)
  );

  bto_capture #(.ADDR_W(ADDR_W), .UID_W(UID_W)) i_capture (
    .clk(clk), .rst(rst), .hit_i(hit), .clr_i(clr), .addr_i(bus_addr),
    .uid_i(bus_uid), .addr_o(cap_addr), .uid_o(cap_uid), .irq_o(irq)
  );

  assign bus_ready = slv_ready | forcing;
  assign bus_err   = forcing;
  assign tmo_irq   = irq;

  p_err_with_ready_r3: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_ready);

  p_irq_on_force_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_err) |-> tmo_irq);
endmodule

// File: tb/test_bus_timeout_wdog.sv
module test_bus_timeout_wdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [6:0]  bus_uid = '0;
  logic        slv_ready = 1'b0;
  logic        bus_ready;
  logic        bus_err;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tmo_irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bus_timeout_wdog i_bus_timeout_wdog (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_addr(bus_addr), .bus_uid(bus_uid),
    .slv_ready(slv_ready), .bus_ready(bus_ready), .bus_err(bus_err),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tmo_irq(tmo_irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    cfg_sel = sel;
    @(posedge clk); #1;
    val = cfg_rdata;
  endtask

  // Runs one access; the slave answers in access cycle lat (first cycle is 0).
  task automatic access(input logic [31:0] a, input logic [6:0] u, input int lat,
                        output int done_at, output logic err);
    int k = 0;
    @(negedge clk);
    bus_req = 1'b1; bus_addr = a; bus_uid = u;
    done_at = -1; err = 1'b0;
    while (k < 300) begin
      slv_ready = (k == lat);
      #1;
      if (bus_ready) begin
        done_at = k; err = bus_err;
        @(posedge clk); #1;
        bus_req = 1'b0; slv_ready = 1'b0;
        break;
      end
      @(negedge clk);
      k++;
    end
  endtask

  function automatic logic [31:0] ctrl(input int thr, input logic en, input logic clr);
    return {14'd0, clr, en, 16'(thr)};
  endfunction

  initial begin
    logic [31:0] rv;
    int          dn;
    logic        er;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 / R10: reset values through the register port
    reg_rd(2'd0, rv);
    chk(rv == 32'h0001_FFFF, "R1 R10 ctrl reset", rv, 32'h0001_FFFF);
    reg_rd(2'd1, rv);
    chk(rv == 0, "R1 addr reset", rv, 0);
    reg_rd(2'd2, rv);
    chk(rv == 0, "R1 uid reset", rv, 0);
    reg_rd(2'd3, rv);
    chk(rv == 0 && tmo_irq == 0, "R1 irq reset", rv, 0);

    // R2 R3 R4: sweep limit and slave latency; accesses run back to back
    for (int t = 0; t <= 5; t++) begin
      reg_wr(2'd0, ctrl(t, 1'b1, 1'b1));
      reg_rd(2'd0, rv);
      chk(rv == ctrl(t, 1'b1, 1'b0), "R10 ctrl readback", rv, ctrl(t, 1'b1, 1'b0));
      for (int l = 0; l <= 7; l++) begin
        access(32'h1000 + l, 7'(l), l, dn, er);
        if (l <= t) begin
          chk(dn == l && er == 1'b0, "R2 R4 slave completion", dn, l);
        end else begin
          chk(dn == t + 1 && er == 1'b1, "R3 R4 forced completion", dn, t + 1);
        end
      end
    end

    // R7: clear by single write of bit 17
    reg_wr(2'd0, ctrl(3, 1'b1, 1'b1));
    reg_rd(2'd3, rv);
    chk(rv == 0 && tmo_irq == 0, "R7 irq cleared", rv, 0);

    // R5 R6 R7: first capture
    access(32'hCAFE_0001, 7'h55, 50, dn, er);
    chk(dn == 4 && er, "R3 forced at limit 3", dn, 4);
    reg_rd(2'd1, rv);
    chk(rv == 32'hCAFE_0001, "R5 address capture", rv, 32'hCAFE_0001);
    reg_rd(2'd2, rv);
    chk(rv == 32'h55, "R6 uid capture", rv, 32'h55);
    reg_rd(2'd3, rv);
    chk(rv == 1 && tmo_irq == 1, "R7 irq set", rv, 1);

    // R8: second fault while pending leaves capture alone
    access(32'h0BAD_0002, 7'h2A, 50, dn, er);
    chk(dn == 4 && er, "R3 second forced", dn, 4);
    reg_rd(2'd1, rv);
    chk(rv == 32'hCAFE_0001, "R8 address held", rv, 32'hCAFE_0001);
    reg_rd(2'd2, rv);
    chk(rv == 32'h55, "R8 uid held", rv, 32'h55);
    repeat (5) @(posedge clk);
    #1 chk(tmo_irq == 1, "R7 irq sticky", tmo_irq, 1);

    // R7 R10: clear, bit 17 reads back 0, then recapture
    reg_wr(2'd0, ctrl(3, 1'b1, 1'b1));
    reg_rd(2'd0, rv);
    chk(rv == ctrl(3, 1'b1, 1'b0), "R10 clear bit reads 0", rv, ctrl(3, 1'b1, 1'b0));
    chk(tmo_irq == 0, "R7 irq after clear", tmo_irq, 0);
    access(32'h7777_0003, 7'h7F, 50, dn, er);
    reg_rd(2'd1, rv);
    chk(rv == 32'h7777_0003, "R5 recapture address", rv, 32'h7777_0003);
    reg_rd(2'd2, rv);
    chk(rv == 32'h7F, "R6 recapture uid", rv, 32'h7F);

    // R9: protection off
    reg_wr(2'd0, ctrl(2, 1'b0, 1'b1));
    access(32'h9999_0004, 7'h01, 20, dn, er);
    chk(dn == 20 && er == 0, "R9 pass-through when disabled", dn, 20);
    chk(tmo_irq == 0, "R9 no irq when disabled", tmo_irq, 0);
    reg_rd(2'd1, rv);
    chk(rv == 32'h7777_0003, "R9 capture untouched", rv, 32'h7777_0003);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule